// File: doc/BRIEF.md
# Bit-Serial Circulating Register with Drive and Retain Modes

This block holds one 8-bit data word as a serial stream, least significant bit first, inside a 12-bit frame. The word occupies the first eight slots of the frame and the last four slots are always zero. The storage is a ring of twelve flip-flops that advances one place on every clock. Eight stages hold the word. The other four stages are delay that matches the latency of the four-stage arithmetic unit fed by this register. Because of this, every operation on the register lasts exactly twelve clocks.

Two mode bits, taken at the first cycle of each frame, set what happens during that frame. The drive bit decides whether the circulating stream goes to the arithmetic unit or whether zeros go there instead. The retain bit decides whether the ring feeds its own output back into its input, which keeps the word, or whether it takes in a new word from the serial input. A monitor output always shows the bit leaving the ring, whatever the mode bits are. A frame-start strobe marks slot 0 so that neighbouring blocks can align to the frame.

Top module: `serial_loop_reg`

## Requirements
- R1: In a frame with `hold_i`=0, the value on `ser_in` in slot k (k = 0..7, LSB in slot 0) is stored and appears on `mon_out` in slot k of the following frame.
- R2: A frame is 12 cycles long. `frame_start` is 1 exactly in slot 0 of each frame and 0 in slots 1..11.
- R3: `mon_out` is 0 in slots 8..11 of every frame, even when `ser_in` is 1 in those slots.
- R4: In a frame with `hold_i`=1, the stored word stays the same and `ser_in` has no effect. The next frame shows the same bits on `mon_out`.
- R5: When the frame's drive bit is 1, `alu_out` equals `mon_out` in every slot. When it is 0, `alu_out` is 0.
- R6: `mon_out` shows the bit stored for the current slot whatever values the drive and retain bits have.
- R7: `drive_en_i` and `hold_i` are sampled in slot 0 and apply to the whole frame. Changes to them in slots 1..11 have no effect on that frame.
- R8: A synchronous active-high `rst` clears all twelve stored bits to 0, puts the frame in slot 0, and sets the held mode to drive off and retain off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial write data, LSB first, aligned to the frame |
| drive_en_i | input | 1 | 1 = send the stream to the arithmetic unit, 0 = send zeros; sampled in slot 0 |
| hold_i | input | 1 | 1 = recirculate and keep the word, 0 = write in `ser_in`; sampled in slot 0 |
| alu_out | output | 1 | Serial stream to the arithmetic unit |
| mon_out | output | 1 | Monitor view of the bit leaving the ring |
| frame_start | output | 1 | High in slot 0 of each frame |

## Verification
The hardest condition to reach is a mode bit that changes in the middle of a frame. From the ports, such a change looks like a valid command, and only a frame-accurate model can show that it was ignored. The stimulus picks a mode in slot 0 of each frame and then flips the mode inputs at random in later slots. The reference model latches the mode only at slot 0, so any early response to a flip shows up on `alu_out` or in the next frame's word on `mon_out`. Directed frames add a known write-then-keep sequence, pad slots driven with ones, and a reset in the middle of a frame.

// File: rtl/serial_loop_reg_pkg.sv
package serial_loop_reg_pkg;

    parameter int DEF_WORD_W = 8;
    parameter int DEF_PAD_W  = 4;

    typedef struct packed {
        logic drive;
        logic hold;
    } mode_t;

    localparam mode_t MODE_RESET = '{drive: 1'b0, hold: 1'b0};

    typedef enum logic [1:0] {
        SRC_LOOP = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_PAD  = 2'd2
    } src_e;

    function automatic src_e pick_source(input logic hold, input logic in_pad);
        if (hold)
            return SRC_LOOP;
        else if (in_pad)
            return SRC_PAD;
        else
            return SRC_EXT;
    endfunction

    function automatic logic source_bit(input src_e src, input logic loop_bit,
                                        input logic ext_bit);
        case (src)
            SRC_LOOP: return loop_bit;
            SRC_EXT:  return ext_bit;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/slp_frame_pacer.sv
module slp_frame_pacer #(
    parameter int WORD_W = 8,
    parameter int PAD_W  = 4
) (
    input  logic clk,
    input  logic rst,
    output logic first_o,
    output logic pad_o
);
    localparam int FRAME_LEN = WORD_W + PAD_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] PAD_START = POS_W'(WORD_W);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (pos_q == LAST_POS)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    assign first_o = (pos_q == '0);
    assign pad_o   = (pos_q >= PAD_START);
endmodule

// File: rtl/slp_mode_hold.sv
module slp_mode_hold
    import serial_loop_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  first_i,
    input  mode_t mode_i,
    output mode_t mode_eff_o,
    output mode_t mode_q_o
);
    mode_t mode_q;

    assign mode_eff_o = first_i ? mode_i : mode_q;
    assign mode_q_o   = mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_RESET;
        else
            mode_q <= mode_eff_o;
    end
endmodule

// File: rtl/slp_ring.sv
module slp_ring #(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    output logic out_bit
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= {in_bit, stage_q[DEPTH-1:1]};
    end

    assign out_bit = stage_q[0];
endmodule

// File: rtl/serial_loop_reg.sv
module serial_loop_reg
    import serial_loop_reg_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int PAD_W  = DEF_PAD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic drive_en_i,
    input  logic hold_i,
    output logic alu_out,
    output logic mon_out,
    output logic frame_start
);
    localparam int FRAME_LEN = WORD_W + PAD_W;

    logic  first;
    logic  in_pad;
    mode_t mode_in;
    mode_t mode_eff;
    mode_t mode_q;
    src_e  src;
    logic  ring_in;
    logic  ring_out;

    slp_frame_pacer #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .first_o (first),
        .pad_o   (in_pad)
    );

    assign mode_in = '{drive: drive_en_i, hold: hold_i};

    slp_mode_hold u_mode (
        .clk        (clk),
        .rst        (rst),
        .first_i    (first),
        .mode_i     (mode_in),
        .mode_eff_o (mode_eff),
        .mode_q_o   (mode_q)
    );

    assign src     = pick_source(mode_eff.hold, in_pad);
    assign ring_in = source_bit(src, ring_out, ser_in);

    slp_ring #(.DEPTH(FRAME_LEN)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (ring_in),
        .out_bit (ring_out)
    );

    assign mon_out     = ring_out;
    assign alu_out     = mode_eff.drive & ring_out;
    assign frame_start = first;
endmodule

// File: rtl/serial_loop_reg_chk.sv
module serial_loop_reg_chk
    import serial_loop_reg_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int PAD_W  = DEF_PAD_W
) (
    input logic  clk,
    input logic  rst,
    input logic  drive_en_i,
    input logic  alu_out,
    input logic  mon_out,
    input logic  frame_start,
    input mode_t mode_q
);
    localparam int FRAME_LEN = WORD_W + PAD_W;
    localparam int POS_W     = $clog2(FRAME_LEN);

    logic [POS_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (slot_q == POS_W'(FRAME_LEN - 1))
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    AST_START_SLOT: assert property (@(posedge clk) disable iff (rst)
        frame_start == (slot_q == '0)); // R2

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (slot_q >= POS_W'(WORD_W)) |-> !mon_out); // R3

    AST_DRIVE_OFF_START: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !drive_en_i) |-> !alu_out); // R5

    AST_DRIVE_OFF_MID: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !mode_q.drive) |-> !alu_out); // R5

    AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && mode_q.drive) |-> (alu_out == mon_out)); // R5

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(mode_q)); // R7

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (frame_start && !mon_out && mode_q == MODE_RESET)); // R8
endmodule

bind serial_loop_reg serial_loop_reg_chk #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .drive_en_i  (drive_en_i),
    .alu_out     (alu_out),
    .mon_out     (mon_out),
    .frame_start (frame_start),
    .mode_q      (mode_q)
);

// File: tb/test_serial_loop_reg.sv
`timescale 1ns/1ps
module test_serial_loop_reg;
    localparam int WW = 8;
    localparam int FL = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic drive_en_i = 1'b0;
    logic hold_i = 1'b0;
    logic alu_out, mon_out, frame_start;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [FL-1:0] model;
    logic [FL-1:0] seen;
    int pos;
    logic m_drive, m_hold;

    always #10 clk = ~clk;

    serial_loop_reg i_serial_loop_reg (
        .clk(clk), .rst(rst), .ser_in(ser_in), .drive_en_i(drive_en_i),
        .hold_i(hold_i), .alu_out(alu_out), .mon_out(mon_out),
        .frame_start(frame_start)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s slot %0d: got %b expected %b", tag, pos, act, exp);
        end
    endtask

    function automatic logic exp_drive(input logic en, input logic b);
        return en ? b : 1'b0;
    endfunction

    function automatic logic exp_write(input logic hold, input int p,
                                       input logic cur, input logic si);
        if (hold) return cur;
        return (p < WW) ? si : 1'b0;
    endfunction

    // one slot: called just after a negedge, returns just after the next
    task automatic slot(input logic si, input logic de, input logic ho);
        ser_in = si; drive_en_i = de; hold_i = ho;
        #1;
        if (pos == 0) begin m_drive = de; m_hold = ho; end
        chk(frame_start, (pos == 0), "R2 frame_start");
        chk(mon_out, model[pos], "R6 mon_out");
        chk(alu_out, exp_drive(m_drive, model[pos]), "R5 alu_out");
        if (pos >= WW) chk(mon_out, 1'b0, "R3 pad slot");
        seen[pos] = mon_out;
        model[pos] = exp_write(m_hold, pos, model[pos], si);
        pos = (pos + 1) % FL;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0; pos = 0; m_drive = 1'b0; m_hold = 1'b0;
        #1;
        chk(frame_start, 1'b1, "R8 reset slot");
        chk(mon_out, 1'b0, "R8 reset data");
        chk(alu_out, 1'b0, "R8 reset drive");
    endtask

    // write a word in one frame with given drive bit, pads driven with pad_val
    task automatic write_frame(input logic [WW-1:0] w, input logic de, input logic pad_val);
        for (int k = 0; k < FL; k++)
            slot((k < WW) ? w[k] : pad_val, de, 1'b0);
    endtask

    task automatic keep_frame(input logic de, input bit noisy);
        for (int k = 0; k < FL; k++) begin
            logic n_si, n_de, n_ho;
            n_si = noisy ? 1'($urandom) : 1'b0;
            n_de = (k == 0 || !noisy) ? de : 1'($urandom);
            n_ho = (k == 0 || !noisy) ? 1'b1 : 1'($urandom);
            slot(n_si, n_de, n_ho);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();

        // R1: write 0xDB, then keep and read it back
        write_frame(8'hDB, 1'b0, 1'b0);
        keep_frame(1'b1, 1'b0);
        vectors++;
        if (seen[WW-1:0] !== 8'hDB) begin
            fails++;
            $display("FAIL R1 word: got %h expected %h", seen[WW-1:0], 8'hDB);
        end

        // R3: pads driven high must store zero
        write_frame(8'hEC, 1'b1, 1'b1);
        keep_frame(1'b0, 1'b0);
        vectors++;
        if (seen !== 12'h0EC) begin
            fails++;
            $display("FAIL R3 frame: got %h expected %h", seen, 12'h0EC);
        end

        // R4 / R7: keep frames with noisy ser_in and mid-frame mode flips
        for (int f = 0; f < 20; f++) keep_frame(1'($urandom), 1'b1);
        keep_frame(1'b1, 1'b0);
        vectors++;
        if (seen[WW-1:0] !== 8'hEC) begin
            fails++;
            $display("FAIL R4 kept word: got %h expected %h", seen[WW-1:0], 8'hEC);
        end

        // R8: reset in the middle of a frame with a nonzero word
        write_frame(8'hFF, 1'b1, 1'b0);
        repeat (5) slot(1'b1, 1'b1, 1'b1);
        do_reset();
        keep_frame(1'b1, 1'b0);
        vectors++;
        if (seen !== '0) begin
            fails++;
            $display("FAIL R8 cleared word: got %h expected %h", seen, 12'h000);
        end

        // random mix: per-frame modes, mid-frame flips (R7), random data (R1, R6)
        for (int f = 0; f < 800; f++) begin
            logic f_de, f_ho;
            f_de = 1'($urandom);
            f_ho = ($urandom % 10) < 6;
            for (int k = 0; k < FL; k++) begin
                logic si, de, ho;
                si = 1'($urandom);
                de = (k == 0) ? f_de : (($urandom % 4 == 0) ? ~f_de : f_de);
                ho = (k == 0) ? f_ho : (($urandom % 4 == 0) ? ~f_ho : f_ho);
                slot(si, de, ho);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule